// File: doc/BRIEF.md
# Video DRAM Bus Transaction Decoder

A passive observer for a multiplexed-address video memory bus. Once per clock it may receive a 16-bit snapshot of the bus pins, qualified by a valid strobe. From the row strobe, column strobe, output-enable/transfer strobe and write strobe it works out which kind of access each strobe sequence is. It then reports the access as a single event carrying the assembled 16-bit bus address, a remapped logical address and a 2-bit kind code.

Four kinds of access are told apart:
- A column-first refresh.
- A read-transfer cycle, which has the enable strobe low when the row strobe falls.
- A normal read.
- A normal write.

A read whose address equals the address of the access before it is marked as redundant. This lets a debug or profiling fabric count wasted fetches without software having to parse bus traces.

Top module: `vdram_txn_decoder`

## Requirements
- R1: Strobe positions in `smp_word` are: column strobe at bit 1, row strobe at bit 12, write strobe at bit 13, enable/transfer strobe at bit 14. All four are active low. A falling edge is a 1 in the previous valid sample followed by a 0 in the current valid sample. Samples with `smp_valid` low are ignored entirely. The first valid sample after reset never produces an edge.
- R2: The 8-bit bus address in a sample is built from three fields. Address bits 3:0 come from sample bits 5:2, address bits 6:4 come from sample bits 11:9, and address bit 7 comes from sample bit 6. All other sample bits are ignored.
- R3: When idle, a row-strobe fall latches the row address. The level of the enable strobe in that same sample selects the cycle type: low means read-transfer, high means RAM cycle. A row fall takes priority over a column fall in the same sample.
- R4: In a read-transfer cycle, the next column-strobe fall latches the column. At that point a kind-0 event is emitted with address `{row, column}`, and the decoder returns to idle.
- R5: In a RAM cycle, the decoder waits after the column latch. An enable-strobe fall then emits a read event (kind 1), or a write-strobe fall emits a write event (kind 2). If both fall in the same sample, the read wins. Either event returns the decoder to idle.
- R6: When idle, a column-strobe fall with no row fall in the same sample enters a column-first state. A following row-strobe fall emits a refresh event (kind 3) with both addresses zero.
- R7: `evt_logical` is formed from the bus address A as follows: bits 1:0 are A[1:0], bits 9:2 are A[15:8], and bits 15:10 are A[7:2].
- R8: Every column latch records the full address. A read event has `evt_redundant` high exactly when its address equals the address recorded by the previous column latch. After reset there is no previous address, so the first read is never redundant.
- R9: `evt_valid` is a registered one-cycle pulse. It is high in the cycle after the clock edge that captured the triggering sample. The kind and address outputs are valid with it.
- R10: A synchronous active-high reset returns the decoder to idle, forgets the previous sample and previous address, and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Qualifies `smp_word` in this cycle |
| smp_word | input | 16 | Snapshot of the bus pins |
| evt_valid | output | 1 | One-cycle event pulse |
| evt_kind | output | 2 | 0 read-transfer, 1 read, 2 write, 3 refresh |
| evt_addr | output | 16 | Bus address, row in the upper byte |
| evt_logical | output | 16 | Remapped logical address |
| evt_redundant | output | 1 | Read repeats the previous access address |

## Verification
The single-pulse and refresh-address assertions take for granted that the bus obeys DRAM strobe discipline. A strobe must be seen high again before it can fall a second time, so two events can never come from back-to-back valid samples. The stimulus keeps to this: every access ends with an all-strobes-high sample. Samples with the valid strobe low may carry arbitrary strobe levels, which exercises the rule that only valid samples are compared. Reset is also applied in the middle of an access to show that a partly seen sequence emits nothing.

// File: rtl/vdram_pkg.sv
package vdram_pkg;

  localparam int SMP_W  = 16;
  localparam int ROW_W  = 8;
  localparam int ADDR_W = 2 * ROW_W;

  // strobe slots inside the edge/level vectors
  localparam int STB_CAS = 0;
  localparam int STB_RAS = 1;
  localparam int STB_WE  = 2;
  localparam int STB_OE  = 3;
  localparam int STB_N   = 4;

  typedef enum logic [1:0] {
    EV_XFER    = 2'd0,
    EV_READ    = 2'd1,
    EV_WRITE   = 2'd2,
    EV_REFRESH = 2'd3
  } ev_kind_t;

  // gather the scattered multiplexed address pins into one byte
  function automatic logic [ROW_W-1:0] bus_addr(input logic [SMP_W-1:0] s);
    return {s[6], s[11:9], s[5:2]};
  endfunction

  // fixed row/column remap to the logical address space
  function automatic logic [ADDR_W-1:0] logical_addr(input logic [ADDR_W-1:0] a);
    return {a[7:2], a[15:8], a[1:0]};
  endfunction

endpackage

// File: rtl/vdram_strobe_edges.sv
module vdram_strobe_edges
  import vdram_pkg::*;
#(
  parameter int CAS_BIT = 1,
  parameter int RAS_BIT = 12,
  parameter int WE_BIT  = 13,
  parameter int OE_BIT  = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_word,
  output logic [STB_N-1:0] falls,
  output logic [STB_N-1:0] levels
);

  localparam int BIT_POS [STB_N] = '{CAS_BIT, RAS_BIT, WE_BIT, OE_BIT};

  logic [STB_N-1:0] prev_lvl;
  logic             prev_ok;

  for (genvar g = 0; g < STB_N; g++) begin : g_stb
    assign levels[g] = smp_word[BIT_POS[g]];
    assign falls[g]  = smp_valid & prev_ok & prev_lvl[g] & ~levels[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok  <= 1'b0;
      prev_lvl <= '1;
    end else if (smp_valid) begin
      prev_ok  <= 1'b1;
      prev_lvl <= levels;
    end
  end

  // first valid sample after reset compares against nothing
  p_first_sample_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(prev_ok) |-> $past(falls) == '0);

endmodule

// File: rtl/vdram_txn_fsm.sv
module vdram_txn_fsm
  import vdram_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STB_N-1:0]  falls,
  input  logic [STB_N-1:0]  levels,
  input  logic [ROW_W-1:0]  bus8,
  output logic              fire,
  output ev_kind_t          kind,
  output logic [ADDR_W-1:0] addr,
  output logic              col_latch,
  output logic [ADDR_W-1:0] col_addr
);

  typedef enum logic [1:0] {S_IDLE, S_ROW, S_WAIT, S_CASF} st_t;

  st_t              state, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             xfer_q, xfer_d;
  logic [ADDR_W-1:0] full_q, full_d;

  always_comb begin
    state_d   = state;
    row_d     = row_q;
    xfer_d    = xfer_q;
    full_d    = full_q;
    fire      = 1'b0;
    kind      = EV_XFER;
    addr      = '0;
    col_latch = 1'b0;
    col_addr  = {row_q, bus8};
    unique case (state)
      S_IDLE: begin
        if (falls[STB_RAS]) begin
          row_d   = bus8;
          xfer_d  = ~levels[STB_OE];
          state_d = S_ROW;
        end else if (falls[STB_CAS]) begin
          state_d = S_CASF;
        end
      end
      S_ROW: begin
        if (falls[STB_CAS]) begin
          col_latch = 1'b1;
          full_d    = {row_q, bus8};
          if (xfer_q) begin
            fire    = 1'b1;
            kind    = EV_XFER;
            addr    = {row_q, bus8};
            state_d = S_IDLE;
          end else begin
            state_d = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (falls[STB_OE]) begin
          fire    = 1'b1;
          kind    = EV_READ;
          addr    = full_q;
          state_d = S_IDLE;
        end else if (falls[STB_WE]) begin
          fire    = 1'b1;
          kind    = EV_WRITE;
          addr    = full_q;
          state_d = S_IDLE;
        end
      end
      S_CASF: begin
        if (falls[STB_RAS]) begin
          fire    = 1'b1;
          kind    = EV_REFRESH;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      row_q  <= '0;
      xfer_q <= 1'b0;
      full_q <= '0;
    end else begin
      state  <= state_d;
      row_q  <= row_d;
      xfer_q <= xfer_d;
      full_q <= full_d;
    end
  end

  // a transfer cycle ends at its column latch
  p_xfer_returns_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_ROW && xfer_q && falls[STB_CAS]) |=> state == S_IDLE);

  // a RAM cycle waits for the data strobe after the column latch
  p_ram_waits_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_ROW && !xfer_q && falls[STB_CAS]) |=> state == S_WAIT);

endmodule

// File: rtl/vdram_event_out.sv
module vdram_event_out
  import vdram_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  ev_kind_t          kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              col_latch,
  input  logic [ADDR_W-1:0] col_addr,
  output logic              evt_valid,
  output logic [1:0]        evt_kind,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [ADDR_W-1:0] evt_logical,
  output logic              evt_redundant
);

  logic [ADDR_W-1:0] last_q;
  logic              last_ok;
  logic              red_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid     <= 1'b0;
      evt_kind      <= '0;
      evt_addr      <= '0;
      evt_logical   <= '0;
      evt_redundant <= 1'b0;
      last_q        <= '0;
      last_ok       <= 1'b0;
      red_pend      <= 1'b0;
    end else begin
      evt_valid     <= fire;
      evt_redundant <= fire && (kind == EV_READ) && red_pend;
      if (fire) begin
        evt_kind    <= kind;
        evt_addr    <= addr;
        evt_logical <= logical_addr(addr);
      end
      if (col_latch) begin
        red_pend <= last_ok && (col_addr == last_q);
        last_q   <= col_addr;
        last_ok  <= 1'b1;
      end
    end
  end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> !evt_valid);

  p_refresh_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EV_REFRESH) |-> (evt_addr == '0 && evt_logical == '0));

  p_redundant_read_r8: assert property (@(posedge clk) disable iff (rst)
    evt_redundant |-> (evt_valid && evt_kind == EV_READ));

endmodule

// File: rtl/vdram_txn_decoder.sv
module vdram_txn_decoder
  import vdram_pkg::*;
#(
  parameter int CAS_BIT = 1,
  parameter int RAS_BIT = 12,
  parameter int WE_BIT  = 13,
  parameter int OE_BIT  = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        smp_valid,
  input  logic [15:0] smp_word,
  output logic        evt_valid,
  output logic [1:0]  evt_kind,
  output logic [15:0] evt_addr,
  output logic [15:0] evt_logical,
  output logic        evt_redundant
);

  logic [STB_N-1:0]  falls, levels;
  logic              fire, col_latch;
  ev_kind_t          kind;
  logic [ADDR_W-1:0] addr, col_addr;

  vdram_strobe_edges #(
    .CAS_BIT(CAS_BIT), .RAS_BIT(RAS_BIT), .WE_BIT(WE_BIT), .OE_BIT(OE_BIT)
  ) u_edges (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_word(smp_word),
    .falls(falls), .levels(levels)
  );

  vdram_txn_fsm u_fsm (
    .clk(clk), .rst(rst), .falls(falls), .levels(levels),
    .bus8(bus_addr(smp_word)), .fire(fire), .kind(kind), .addr(addr),
    .col_latch(col_latch), .col_addr(col_addr)
  );

  vdram_event_out u_out (
    .clk(clk), .rst(rst), .fire(fire), .kind(kind), .addr(addr),
    .col_latch(col_latch), .col_addr(col_addr),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_addr(evt_addr),
    .evt_logical(evt_logical), .evt_redundant(evt_redundant)
  );

  // samples without the qualifier never produce an event
  p_valid_gates_r1: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !evt_valid);

endmodule

// File: tb/vdram_txn_decoder_bench.sv
`timescale 1ns/1ps
module vdram_txn_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_word = 16'h7002;
  logic        evt_valid, evt_redundant;
  logic [1:0]  evt_kind;
  logic [15:0] evt_addr, evt_logical;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  vdram_txn_decoder u_vdram_txn_decoder (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_word(smp_word),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_addr(evt_addr),
    .evt_logical(evt_logical), .evt_redundant(evt_redundant)
  );

  typedef struct {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic        red;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // bench-side model of the previous-address record (R8)
  logic [15:0] m_last = '0;
  bit          m_last_ok = 0;
  bit          m_red = 0;

  function automatic logic [15:0] mk(bit ras_n, bit cas_n, bit oe_n, bit we_n, logic [7:0] a);
    logic [15:0] w;
    w = 16'h0100;              // unrelated pin held high (R2: ignored)
    w[12] = ras_n; w[1] = cas_n; w[14] = oe_n; w[13] = we_n;
    w[5:2] = a[3:0]; w[11:9] = a[6:4]; w[6] = a[7];
    w[15] = a[0]; w[7] = a[1]; // unrelated pins toggled (R2)
    return w;
  endfunction

  function automatic logic [15:0] remap(logic [15:0] a);
    return {a[7:2], a[15:8], a[1:0]};
  endfunction

  task automatic put(input bit v, input logic [15:0] w);
    @(negedge clk);
    smp_valid = v;
    smp_word  = w;
  endtask

  task automatic push(input logic [1:0] k, input logic [15:0] a, input bit r, input string t);
    exp_t e;
    e.kind = k; e.addr = a; e.red = r; e.tag = t;
    exp_q.push_back(e);
  endtask

  task automatic model_latch(input logic [15:0] full);
    m_red = m_last_ok && (full == m_last);
    m_last = full;
    m_last_ok = 1;
  endtask

  task automatic ram_access(input logic [7:0] row, input logic [7:0] col, input bit wr, input string t);
    put(1, mk(1, 1, 1, 1, row));
    put(1, mk(0, 1, 1, 1, row));
    model_latch({row, col});
    put(1, mk(0, 0, 1, 1, col));
    push(wr ? 2'd2 : 2'd1, {row, col}, wr ? 1'b0 : m_red, t);
    put(1, wr ? mk(0, 0, 1, 0, col) : mk(0, 0, 0, 1, col));
    put(1, mk(1, 1, 1, 1, 8'h00));
  endtask

  task automatic xfer_access(input logic [7:0] row, input logic [7:0] col, input string t);
    put(1, mk(1, 1, 1, 1, row));
    put(1, mk(0, 1, 0, 1, row));
    model_latch({row, col});
    push(2'd0, {row, col}, 1'b0, t);
    put(1, mk(0, 0, 0, 1, col));
    put(1, mk(1, 1, 1, 1, 8'h00));
  endtask

  task automatic refresh_access(input string t);
    put(1, mk(1, 1, 1, 1, 8'h5A));
    put(1, mk(1, 0, 1, 1, 8'h5A));
    push(2'd3, 16'h0000, 1'b0, t);
    put(1, mk(0, 0, 1, 1, 8'hA5));
    put(1, mk(1, 1, 1, 1, 8'h00));
  endtask

  task automatic do_reset(input string t);
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_last_ok = 0;
    tests++;
    if (evt_valid !== 1'b0 || evt_kind !== 2'd0 || evt_addr !== 16'h0 ||
        evt_logical !== 16'h0 || evt_redundant !== 1'b0) begin
      fails++;
      $display("FAIL %s reset outputs: valid=%0b kind=%0d addr=%h log=%h red=%0b expected all zero",
               t, evt_valid, evt_kind, evt_addr, evt_logical, evt_redundant);
    end
  endtask

  task automatic drain(input string t);
    repeat (4) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s missing events: %0d outstanding, expected 0", t, exp_q.size());
      exp_q.delete();
    end
  endtask

  // monitor / scoreboard (R9: one event per expected item)
  always @(negedge clk) begin
    if (!rst && evt_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected event: kind=%0d addr=%h expected none", evt_kind, evt_addr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (evt_kind !== e.kind || evt_addr !== e.addr ||
            evt_logical !== remap(e.addr) || evt_redundant !== e.red) begin
          fails++;
          $display("FAIL %s event: kind=%0d addr=%h log=%h red=%0b expected kind=%0d addr=%h log=%h red=%0b",
                   e.tag, evt_kind, evt_addr, evt_logical, evt_redundant,
                   e.kind, e.addr, remap(e.addr), e.red);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: run incomplete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset("R10");
    // R1: first valid sample with all strobes low makes no edge
    put(1, mk(0, 0, 0, 0, 8'h00));
    put(1, mk(1, 1, 1, 1, 8'h00));
    // R8: first read after reset is never redundant, even at address 0
    ram_access(8'h00, 8'h00, 0, "R8 first read");
    ram_access(8'h12, 8'h34, 0, "R5 read");
    ram_access(8'h12, 8'h34, 0, "R8 repeat read");
    ram_access(8'h12, 8'h34, 1, "R5 write");
    ram_access(8'h12, 8'h34, 0, "R8 read after write");
    ram_access(8'hA5, 8'hC3, 0, "R8 new read");
    xfer_access(8'h3C, 8'h81, "R4 transfer");
    refresh_access("R6 refresh");
    ram_access(8'hFF, 8'h00, 1, "R7 remap high");
    ram_access(8'h00, 8'hFF, 0, "R7 remap low");
    ram_access(8'h96, 8'h69, 0, "R2 field mix");
    // R3: row and column fall together; row wins
    put(1, mk(1, 1, 1, 1, 8'h47));
    put(1, mk(0, 0, 0, 1, 8'h47));
    put(1, mk(0, 1, 0, 1, 8'h00));
    model_latch({8'h47, 8'hB2});
    push(2'd0, {8'h47, 8'hB2}, 1'b0, "R3 row priority");
    put(1, mk(0, 0, 0, 1, 8'hB2));
    put(1, mk(1, 1, 1, 1, 8'h00));
    // R5: enable and write strobes fall together; read wins
    put(1, mk(1, 1, 1, 1, 8'h0F));
    put(1, mk(0, 1, 1, 1, 8'h0F));
    model_latch({8'h0F, 8'hF0});
    put(1, mk(0, 0, 1, 1, 8'hF0));
    push(2'd1, {8'h0F, 8'hF0}, m_red, "R5 read priority");
    put(1, mk(0, 0, 0, 0, 8'hF0));
    put(1, mk(1, 1, 1, 1, 8'h00));
    // R1: invalid samples with active strobes emit nothing
    put(0, mk(0, 1, 0, 1, 8'h11));
    put(0, mk(0, 0, 0, 1, 8'h22));
    put(0, mk(1, 1, 1, 1, 8'h00));
    put(1, mk(1, 1, 1, 1, 8'h00));
    // R1: edges compare against last valid sample, skipping invalid ones
    put(0, mk(0, 0, 0, 0, 8'h00));
    put(1, mk(0, 1, 0, 1, 8'h6E));
    put(0, mk(1, 1, 1, 1, 8'h00));
    model_latch({8'h6E, 8'h3D});
    push(2'd0, {8'h6E, 8'h3D}, 1'b0, "R1 valid-only compare");
    put(1, mk(0, 0, 0, 1, 8'h3D));
    put(1, mk(1, 1, 1, 1, 8'h00));
    drain("R1 R9 event count");
    // R10: reset in the middle of an access drops it and the address record
    ram_access(8'h12, 8'h34, 0, "R5 read before reset");
    put(1, mk(1, 1, 1, 1, 8'h22));
    put(1, mk(0, 1, 1, 1, 8'h22));
    do_reset("R10 mid-access");
    put(1, mk(0, 0, 1, 1, 8'h33));
    put(1, mk(0, 0, 0, 1, 8'h33));
    put(1, mk(1, 1, 1, 1, 8'h00));
    ram_access(8'h12, 8'h34, 0, "R8 record cleared by reset");
    drain("R10 no event from partial access");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule